// File: doc/BRIEF.md
# SPI Command Frame Builder

This block sits on the host side of a register and DMA access protocol carried over SPI. Upon a start strobe it captures an opcode, a 24-bit address, a 32-bit data word, a transfer length and two option flags. It then emits the command header for that opcode one byte per handshake to a byte-wide SPI shifter. A 7-bit checksum over the header is accumulated while the bytes leave and is appended as the final byte, unless checksumming is turned off.

Each opcode has its own header length and field arrangement. Register commands carry a full or a 16-bit address and an optional data word. Block transfers carry a 16-bit or a 24-bit byte count. Control commands carry a fixed filler pattern. Response parsing and data phases belong to other blocks.

Top module: `spi_cmd_framer`

## Requirements
- R1: Accepted opcodes are 0xC1 to 0xCA and 0xCF. A start with any other opcode gives a one-cycle `op_err` pulse in the next cycle, and no byte is offered (`tx_valid` and `busy` stay low).
- R2: Opcode 0xCA (word read) sends opcode, addr[23:16], addr[15:8], addr[7:0]. Opcode 0xC9 (word write) appends wdata most significant byte first.
- R3: Opcodes 0xC4 (local read) and 0xC3 (local write) send opcode, then addr[15:8] with bit 7 forced high when `clockless` is set, then addr[7:0]. 0xC4 then sends one 0x00 byte. 0xC3 then sends wdata most significant byte first.
- R4: Opcodes 0xC1 and 0xC2 send opcode, three address bytes and len[15:8], len[7:0]. Opcodes 0xC7 and 0xC8 send opcode, three address bytes and len[23:16], len[15:8], len[7:0].
- R5: Opcodes 0xC5 and 0xC6 send opcode followed by three 0x00 bytes. Opcode 0xCF sends opcode followed by three 0xFF bytes.
- R6: With `crc_off` low, one more byte follows the header. It holds, in bits 7:1, the CRC of generator x^7+x^3+1, seeded with 0x7F, over every preceding byte MSB first. Its bit 0 is 0.
- R7: With `crc_off` high, the checksum byte is left out and the frame is one byte shorter.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_data` holds its value and `tx_valid` stays high. The stream advances only on a handshake.
- R9: `busy` rises in the cycle after an accepted start and falls after the handshake of the last byte. `done` pulses for one cycle in that same cycle. A start while `busy` is high is ignored.
- R10: After reset, `busy`, `tx_valid`, `done` and `op_err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame with the current command inputs |
| opcode | input | 8 | Command code |
| addr | input | 24 | Target address |
| wdata | input | 32 | Data word for write commands |
| xfer_len | input | 24 | Byte count for block transfers |
| clockless | input | 1 | Sets bit 7 of the upper address byte in local commands |
| crc_off | input | 1 | Omit the trailing checksum byte |
| tx_data | output | 8 | Byte offered to the shifter |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_ready | input | 1 | Shifter takes the byte this cycle |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse after the last byte |
| op_err | output | 1 | One-cycle pulse for a rejected opcode |

## Verification
The assertions check the stream protocol on every cycle: a stalled byte holds, `busy` only rises after a start, `done` only follows a handshake, and a rejected opcode never coincides with an offered byte. The byte layout of each opcode, the clockless bit, the checksum value, the shortened frame without checksum and the fact that a start during a frame has no effect depend on whole frames. Only the bench's scenarios show these, by comparing each captured frame with one built from the requirements.

// File: rtl/spi_cmd_framer.sv
module spi_cmd_framer #(
  parameter logic [6:0] CRC_SEED = 7'h7F,
  parameter int         HDR_MAX  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic [23:0] addr,
  input  logic [31:0] wdata,
  input  logic [23:0] xfer_len,
  input  logic        clockless,
  input  logic        crc_off,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic        busy,
  output logic        done,
  output logic        op_err
);
  localparam int FW = HDR_MAX * 8;
  localparam int IW = $clog2(HDR_MAX + 1);

  logic [FW-1:0] frm, frm_nxt;
  logic [IW-1:0] idx, npay, npay_nxt;
  logic [6:0]    crc;
  logic          noc, op_ok, last;
  logic [7:0]    hi_loc;

  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic [7:0] b);
    logic [6:0] r;
    logic       fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[6] ^ b[i];
      r  = {r[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return r;
  endfunction

  assign hi_loc = {addr[15] | clockless, addr[14:8]};

  always_comb begin
    frm_nxt  = '0;
    npay_nxt = IW'(4);
    op_ok    = 1'b1;
    case (opcode)
      8'hCA: frm_nxt[FW-1 -: 32] = {opcode, addr};
      8'hC9: begin frm_nxt[FW-1 -: 64] = {opcode, addr, wdata};                   npay_nxt = IW'(8); end
      8'hC4: frm_nxt[FW-1 -: 32] = {opcode, hi_loc, addr[7:0], 8'h00};
      8'hC3: begin frm_nxt[FW-1 -: 56] = {opcode, hi_loc, addr[7:0], wdata};      npay_nxt = IW'(7); end
      8'hC1, 8'hC2: begin frm_nxt[FW-1 -: 48] = {opcode, addr, xfer_len[15:0]};  npay_nxt = IW'(6); end
      8'hC7, 8'hC8: begin frm_nxt[FW-1 -: 56] = {opcode, addr, xfer_len};        npay_nxt = IW'(7); end
      8'hC5, 8'hC6: frm_nxt[FW-1 -: 32] = {opcode, 24'h000000};
      8'hCF: frm_nxt[FW-1 -: 32] = {opcode, 24'hFFFFFF};
      default: op_ok = 1'b0;
    endcase
  end

  assign tx_valid = busy;
  assign tx_data  = (idx == npay) ? {crc, 1'b0} : frm[FW-1 -: 8];
  assign last     = (idx == (noc ? npay - IW'(1) : npay));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      op_err <= 1'b0;
      frm    <= '0;
      npay   <= '0;
      idx    <= '0;
      crc    <= CRC_SEED;
      noc    <= 1'b0;
    end else begin
      done   <= 1'b0;
      op_err <= 1'b0;
      if (!busy && start) begin
        if (op_ok) begin
          busy <= 1'b1;
          frm  <= frm_nxt;
          npay <= npay_nxt;
          noc  <= crc_off;
          idx  <= '0;
          crc  <= CRC_SEED;
        end else begin
          op_err <= 1'b1;
        end
      end else if (busy && tx_ready) begin
        idx <= idx + IW'(1);
        frm <= {frm[FW-9:0], 8'h00};
        if (idx != npay) crc <= crc7_step(crc, frm[FW-1 -: 8]);
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

module spi_cmd_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [7:0] tx_data,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       busy,
  input logic       done,
  input logic       op_err
);
  assert_err_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |-> (!busy && !tx_valid));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(tx_valid && tx_ready)));

  assert_busy_needs_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind spi_cmd_framer spi_cmd_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .tx_data(tx_data),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .busy(busy),
  .done(done), .op_err(op_err)
);

// File: tb/spi_cmd_framer_tb.sv
`timescale 1ns/1ps
module spi_cmd_framer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [23:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [23:0] xfer_len = '0;
  logic        clockless = 1'b0;
  logic        crc_off = 1'b0;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic        busy, done, op_err;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [7:0] exp_b [0:8];
  int         exp_n;
  logic [7:0] cap_b [0:15];

  always #2.5 clk = ~clk;

  spi_cmd_framer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .addr(addr),
    .wdata(wdata), .xfer_len(xfer_len), .clockless(clockless), .crc_off(crc_off),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .busy(busy), .done(done), .op_err(op_err)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // CRC by polynomial long division: seed folded into the first seven message bits
  function automatic logic [6:0] ref_crc(input int n);
    logic [0:79] m;
    logic [7:0]  g;
    logic [6:0]  r;
    int          len;
    g   = 8'b1000_1001;
    m   = '0;
    len = n * 8;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) m[i*8+k] = exp_b[i][7-k];
    for (int k = 0; k < 7; k++) m[k] = m[k] ^ 1'b1;
    for (int i = 0; i < len; i++)
      if (m[i]) for (int k = 0; k < 8; k++) m[i+k] = m[i+k] ^ g[7-k];
    for (int k = 0; k < 7; k++) r[6-k] = m[len+k];
    return r;
  endfunction

  task automatic build_ref(input logic [7:0] op, input logic [23:0] a, input logic [31:0] d,
                           input logic [23:0] s, input bit cl, input bit co);
    logic [7:0] hi;
    hi = a[15:8];
    if (cl) hi[7] = 1'b1;
    exp_b[0] = op;
    case (op)
      8'hCA, 8'hC9: begin
        exp_b[1] = a[23:16]; exp_b[2] = a[15:8]; exp_b[3] = a[7:0]; exp_n = 4;
        if (op == 8'hC9) begin
          exp_b[4] = d[31:24]; exp_b[5] = d[23:16]; exp_b[6] = d[15:8]; exp_b[7] = d[7:0]; exp_n = 8;
        end
      end
      8'hC4: begin exp_b[1] = hi; exp_b[2] = a[7:0]; exp_b[3] = 8'h00; exp_n = 4; end
      8'hC3: begin
        exp_b[1] = hi; exp_b[2] = a[7:0];
        exp_b[3] = d[31:24]; exp_b[4] = d[23:16]; exp_b[5] = d[15:8]; exp_b[6] = d[7:0]; exp_n = 7;
      end
      8'hC1, 8'hC2: begin
        exp_b[1] = a[23:16]; exp_b[2] = a[15:8]; exp_b[3] = a[7:0];
        exp_b[4] = s[15:8]; exp_b[5] = s[7:0]; exp_n = 6;
      end
      8'hC7, 8'hC8: begin
        exp_b[1] = a[23:16]; exp_b[2] = a[15:8]; exp_b[3] = a[7:0];
        exp_b[4] = s[23:16]; exp_b[5] = s[15:8]; exp_b[6] = s[7:0]; exp_n = 7;
      end
      8'hCF: begin exp_b[1] = 8'hFF; exp_b[2] = 8'hFF; exp_b[3] = 8'hFF; exp_n = 4; end
      default: begin exp_b[1] = 8'h00; exp_b[2] = 8'h00; exp_b[3] = 8'h00; exp_n = 4; end
    endcase
    if (!co) begin
      exp_b[exp_n] = {ref_crc(exp_n), 1'b0};
      exp_n++;
    end
  endtask

  task automatic run_frame(input string tag, input logic [7:0] op, input logic [23:0] a,
                           input logic [31:0] d, input logic [23:0] s, input bit cl,
                           input bit co, input bit stall, input bit poke);
    int got, tries, first_bad;
    bit prev_stall, held_ok;
    logic [7:0] prev_data;
    build_ref(op, a, d, s, cl, co);
    @(negedge clk);
    opcode = op; addr = a; wdata = d; xfer_len = s; clockless = cl; crc_off = co;
    tx_ready = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    check(busy === 1'b1 && tx_valid === 1'b1, {tag, " R9 busy after start"}, {busy, tx_valid}, 2'b11);
    got = 0; tries = 0; prev_stall = 0; held_ok = 1; prev_data = '0;
    while (got < exp_n && tries < 100) begin
      @(negedge clk);
      tries++;
      start = 1'b0;
      if (poke && got == 2) begin start = 1'b1; opcode = 8'hCF; end
      tx_ready = !(stall && (tries % 3 == 1));
      #1;
      if (prev_stall && tx_data !== prev_data) held_ok = 0;
      prev_stall = 0;
      if (tx_valid) begin
        if (tx_ready) begin cap_b[got] = tx_data; got++; end
        else begin prev_stall = 1; prev_data = tx_data; end
      end
    end
    start = 1'b0;
    check(got == exp_n, {tag, " byte count"}, got, exp_n);
    first_bad = -1;
    for (int i = 0; i < exp_n; i++) if (first_bad < 0 && cap_b[i] !== exp_b[i]) first_bad = i;
    if (first_bad >= 0) check(0, {tag, " frame bytes"}, cap_b[first_bad], exp_b[first_bad]);
    else check(1, tag, 0, 0);
    if (stall) check(held_ok, {tag, " R8 stalled byte held"}, held_ok, 1);
    @(negedge clk);
    #1;
    check(done === 1'b1 && busy === 1'b0, {tag, " R9 done after last byte"}, {done, busy}, 2'b10);
    tx_ready = 1'b1;
    @(negedge clk);
    #1;
    check(done === 1'b0 && busy === 1'b0 && tx_valid === 1'b0, {tag, " R9 idle after frame"},
          {done, busy, tx_valid}, 3'b000);
    tx_ready = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    check(busy === 1'b0 && tx_valid === 1'b0 && done === 1'b0 && op_err === 1'b0,
          "R10 reset state", {busy, tx_valid, done, op_err}, 4'b0000);
  endtask

  task automatic t_word_ops;
    run_frame("R2 R6 word read", 8'hCA, 24'h12A5F0, 32'h0, 24'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    run_frame("R2 R6 word write", 8'hC9, 24'h00F00D, 32'hDEADBEEF, 24'h0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_local_ops;
    run_frame("R3 local read clockless", 8'hC4, 24'h000024, 32'h0, 24'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    run_frame("R3 local write", 8'hC3, 24'h7E5A3C, 32'h01234567, 24'h0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_block_ops;
    run_frame("R4 block write 16b", 8'hC1, 24'hABCDEF, 32'h0, 24'h9F1234, 1'b0, 1'b0, 1'b0, 1'b0);
    run_frame("R4 block read 24b", 8'hC8, 24'h010203, 32'h0, 24'h9F1234, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_control_ops;
    run_frame("R5 terminate", 8'hC5, 24'h555555, 32'hFFFFFFFF, 24'h1, 1'b1, 1'b0, 1'b0, 1'b0);
    run_frame("R5 repeat", 8'hC6, 24'hAAAAAA, 32'h0, 24'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_frame("R5 reset cmd", 8'hCF, 24'h000000, 32'h0, 24'h0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_no_crc;
    run_frame("R7 word write no crc", 8'hC9, 24'h102030, 32'hCAFEF00D, 24'h0, 1'b0, 1'b1, 1'b0, 1'b0);
    run_frame("R7 local read no crc", 8'hC4, 24'h001001, 32'h0, 24'h0, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_stall;
    run_frame("R8 stalled block read", 8'hC7, 24'h445566, 32'h0, 24'h000100, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_start_while_busy;
    run_frame("R9 start ignored", 8'hC2, 24'h0A0B0C, 32'h0, 24'h004000, 1'b0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_bad_opcode;
    @(negedge clk);
    opcode = 8'hCB; start = 1'b1; tx_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    check(op_err === 1'b1 && busy === 1'b0 && tx_valid === 1'b0, "R1 bad opcode flagged",
          {op_err, busy, tx_valid}, 3'b100);
    @(negedge clk);
    #1;
    check(op_err === 1'b0 && tx_valid === 1'b0 && done === 1'b0, "R1 bad opcode sends nothing",
          {op_err, tx_valid, done}, 3'b000);
    tx_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_word_ops();
    t_local_ops();
    t_block_ops();
    t_control_ops();
    t_no_crc();
    t_stall();
    t_start_while_busy();
    t_bad_opcode();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule